// File: doc/BRIEF.md
# Frame Timestamp Capture and Serializer

This block keeps a free-running timestamp counter in a capture clock domain that ticks every 10 ns, so the count is directly a time in 10 ns units. When the active-low start-of-frame strobe is first seen low on a rising capture clock edge, the current count is registered into a snapshot register. No transparent latch is involved. The snapshot is handed to a separate transmit clock domain. The handover uses a request/acknowledge toggle pair, and each toggle passes through a multi-flop synchronizer.

On the transmit side, a send request loads a private copy of the most recently received snapshot. The block then emits that copy on a byte-wide bus, one byte per transmit cycle, highest byte first, with a byte-valid strobe and a busy flag. The timestamp width, the synchronizer depth and the output datapath variant (shift register or indexed byte multiplexer) are parameters. Both datapath variants behave identically at the ports.

Top module: `ts_snap_tx`

## Requirements
- R1: While either reset is asserted and in the first transmit cycle after it, `byte_o` is 0, and `byte_vld_o` and `busy_o` are low.
- R2: The counter is 0 in the first capture cycle after reset and increases by one on every capture clock edge. A capture stores the count value present in the cycle in which `sof_n_i` is sampled low.
- R3: An accepted send produces TS_W/8 consecutive transmit cycles with `byte_vld_o` high, starting in the cycle after the edge that samples `send_i`. Byte k is bits 8k+7 down to 8k, and the bytes are sent in the order k = TS_W/8-1 down to 0. `byte_o` is 0 whenever `byte_vld_o` is low.
- R4: `busy_o` is high in exactly the cycles in which bytes are presented. A send is accepted only when `busy_o` is low.
- R5: Only the first capture cycle of a low period on `sof_n_i` captures. Holding the strobe low captures once, and it must return high before the next capture.
- R6: While a snapshot has not yet been acknowledged by the transmit domain, a new falling strobe is ignored and the snapshot register stays unchanged.
- R7: A send request while `busy_o` is high is ignored: the burst is neither restarted nor lengthened.
- R8: A burst sends the snapshot held at the moment of acceptance. A snapshot arriving during a burst affects only later bursts, and a repeated send with no new capture resends the same value.
- R9: The counter wraps from all ones to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk_i | input | 1 | Capture clock, 10 ns tick |
| cap_rst_i | input | 1 | Synchronous active-high reset of the capture domain |
| sof_n_i | input | 1 | Active-low start-of-frame strobe, synchronous to cap_clk_i |
| tx_clk_i | input | 1 | Transmit clock |
| tx_rst_i | input | 1 | Synchronous active-high reset of the transmit domain |
| send_i | input | 1 | Request to send the held timestamp |
| byte_o | output | 8 | Current timestamp byte |
| byte_vld_o | output | 1 | High for one transmit cycle per byte |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
The bench targets several corner cases; each catches a distinct class of bug:
- A strobe held low for many cycles exposes a level-triggered capture, which would keep overwriting the snapshot and send a later count.
- A second falling strobe a couple of cycles after the first lands inside the handshake window. A design without the pending guard would replace the value in flight.
- A send request in the middle of a burst would restart or stretch the byte stream if busy were not honoured.
- A capture arriving during a burst would mix bytes of two timestamps if the burst read the live holding register.
- A narrow 16-bit instance is run past its wrap point, which catches a counter that saturates or stops.

// File: rtl/ts_snap_pkg.sv
package ts_snap_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_RUN  = 1'b1
   } ser_state_e;
endpackage

// File: rtl/ts_sync_bit.sv
module ts_sync_bit #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '0;
      else       chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
   parameter int unsigned TS_W = 64
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            sof_n_i,
   input  logic            ready_i,
   output logic [TS_W-1:0] cnt_o,
   output logic [TS_W-1:0] snap_o,
   output logic            load_o
);
   logic [TS_W-1:0] cnt_q;
   logic [TS_W-1:0] snap_q;
   logic            sof_prev_q;
   logic            fall;

   assign fall   = !sof_n_i && sof_prev_q;
   assign load_o = fall && ready_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q      <= '0;
         snap_q     <= '0;
         sof_prev_q <= 1'b1;
      end else begin
         cnt_q      <= cnt_q + 1'b1;
         sof_prev_q <= sof_n_i;
         if (load_o) snap_q <= cnt_q;
      end
   end

   assign cnt_o  = cnt_q;
   assign snap_o = snap_q;
endmodule

// File: rtl/ts_handoff.sv
module ts_handoff #(
   parameter int unsigned TS_W   = 64,
   parameter int unsigned SYNC_N = 2
) (
   input  logic            src_clk_i,
   input  logic            src_rst_i,
   input  logic            load_i,
   output logic            src_ready_o,
   input  logic [TS_W-1:0] data_i,
   input  logic            dst_clk_i,
   input  logic            dst_rst_i,
   output logic [TS_W-1:0] data_o
);
   logic            req_q;
   logic            ack_s;
   logic            req_s;
   logic            ack_q;
   logic [TS_W-1:0] hold_q;

   always_ff @(posedge src_clk_i) begin
      if (src_rst_i)   req_q <= 1'b0;
      else if (load_i) req_q <= ~req_q;
   end

   assign src_ready_o = (req_q == ack_s);

   ts_sync_bit #(.STAGES(SYNC_N)) u_req_sync (
      .clk_i (dst_clk_i),
      .rst_i (dst_rst_i),
      .d_i   (req_q),
      .q_o   (req_s)
   );

   always_ff @(posedge dst_clk_i) begin
      if (dst_rst_i) begin
         ack_q  <= 1'b0;
         hold_q <= '0;
      end else if (req_s != ack_q) begin
         hold_q <= data_i;
         ack_q  <= req_s;
      end
   end

   ts_sync_bit #(.STAGES(SYNC_N)) u_ack_sync (
      .clk_i (src_clk_i),
      .rst_i (src_rst_i),
      .d_i   (ack_q),
      .q_o   (ack_s)
   );

   assign data_o = hold_q;
endmodule

// File: rtl/ts_serializer.sv
module ts_serializer
   import ts_snap_pkg::*;
#(
   parameter int unsigned TS_W      = 64,
   parameter bit          SHIFT_OUT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              send_i,
   input  logic [TS_W-1:0]   frame_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              vld_o,
   output logic              busy_o
);
   localparam int unsigned NB    = TS_W / BYTE_W;
   localparam int unsigned IDX_W = $clog2(NB);

   ser_state_e        state_q;
   logic [IDX_W-1:0]  left_q;
   logic              accept;
   logic              last;
   logic [BYTE_W-1:0] cur_byte;

   assign accept = (state_q == SER_IDLE) && send_i;
   assign last   = (left_q == '0);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= SER_IDLE;
         left_q  <= '0;
      end else begin
         case (state_q)
            SER_IDLE: if (send_i) begin
               state_q <= SER_RUN;
               left_q  <= IDX_W'(NB - 1);
            end
            SER_RUN: begin
               if (last) state_q <= SER_IDLE;
               else      left_q  <= left_q - 1'b1;
            end
            default: state_q <= SER_IDLE;
         endcase
      end
   end

   generate
      if (SHIFT_OUT) begin : g_shift
         logic [TS_W-1:0] sh_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)                    sh_q <= '0;
            else if (accept)              sh_q <= frame_i;
            else if (state_q == SER_RUN)  sh_q <= sh_q << BYTE_W;
         end
         assign cur_byte = sh_q[TS_W-1 -: BYTE_W];
      end else begin : g_mux
         logic [TS_W-1:0]   fr_q;
         logic [BYTE_W-1:0] lanes [NB];
         always_ff @(posedge clk_i) begin
            if (rst_i)       fr_q <= '0;
            else if (accept) fr_q <= frame_i;
         end
         for (genvar k = 0; k < NB; k++) begin : g_lane
            assign lanes[k] = fr_q[k*BYTE_W +: BYTE_W];
         end
         assign cur_byte = lanes[left_q];
      end
   endgenerate

   assign vld_o  = (state_q == SER_RUN);
   assign busy_o = (state_q == SER_RUN);
   assign byte_o = (state_q == SER_RUN) ? cur_byte : '0;
endmodule

// File: rtl/ts_snap_tx.sv
module ts_snap_tx
   import ts_snap_pkg::*;
#(
   parameter int unsigned TS_W      = 64,
   parameter int unsigned SYNC_N    = 2,
   parameter bit          SHIFT_OUT = 1'b0
) (
   input  logic              cap_clk_i,
   input  logic              cap_rst_i,
   input  logic              sof_n_i,
   input  logic              tx_clk_i,
   input  logic              tx_rst_i,
   input  logic              send_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_vld_o,
   output logic              busy_o
);
   generate
      if ((TS_W % BYTE_W) != 0 || TS_W < 2 * BYTE_W) begin : g_bad_width
         $error("ts_snap_tx: TS_W must be a multiple of 8 and at least 16");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("ts_snap_tx: SYNC_N must be at least 2");
      end
   endgenerate

   logic [TS_W-1:0] cnt_w;
   logic [TS_W-1:0] snap_w;
   logic [TS_W-1:0] hold_w;
   logic            load_w;
   logic            ready_w;

   ts_capture #(.TS_W(TS_W)) u_cap (
      .clk_i   (cap_clk_i),
      .rst_i   (cap_rst_i),
      .sof_n_i (sof_n_i),
      .ready_i (ready_w),
      .cnt_o   (cnt_w),
      .snap_o  (snap_w),
      .load_o  (load_w)
   );

   ts_handoff #(.TS_W(TS_W), .SYNC_N(SYNC_N)) u_xfer (
      .src_clk_i   (cap_clk_i),
      .src_rst_i   (cap_rst_i),
      .load_i      (load_w),
      .src_ready_o (ready_w),
      .data_i      (snap_w),
      .dst_clk_i   (tx_clk_i),
      .dst_rst_i   (tx_rst_i),
      .data_o      (hold_w)
   );

   ts_serializer #(.TS_W(TS_W), .SHIFT_OUT(SHIFT_OUT)) u_ser (
      .clk_i   (tx_clk_i),
      .rst_i   (tx_rst_i),
      .send_i  (send_i),
      .frame_i (hold_w),
      .byte_o  (byte_o),
      .vld_o   (byte_vld_o),
      .busy_o  (busy_o)
   );
endmodule

// File: rtl/ts_snap_tx_chk.sv
module ts_snap_tx_chk #(
   parameter int unsigned TS_W = 64
) (
   input logic            cap_clk,
   input logic            cap_rst,
   input logic            tx_clk,
   input logic            tx_rst,
   input logic            sof_n,
   input logic            send,
   input logic            vld,
   input logic            busy,
   input logic [TS_W-1:0] cnt,
   input logic [TS_W-1:0] snap,
   input logic            load,
   input logic            ready
);
   localparam int unsigned NB    = TS_W / 8;
   localparam int unsigned RUN_W = $clog2(NB + 2);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge tx_clk) begin
      if (tx_rst)   run_q <= '0;
      else if (vld) run_q <= run_q + 1'b1;
      else          run_q <= '0;
   end

   assert_count_step_R9: assert property (@(posedge cap_clk) disable iff (cap_rst)
      !$past(cap_rst) |-> (cnt == TS_W'($past(cnt) + 1'b1)));

   assert_capture_low_R5: assert property (@(posedge cap_clk) disable iff (cap_rst)
      load |-> !sof_n);

   assert_single_capture_R5: assert property (@(posedge cap_clk) disable iff (cap_rst)
      load |=> !load);

   assert_snap_held_R6: assert property (@(posedge cap_clk) disable iff (cap_rst)
      (!ready && ($past(ready) == 1'b0)) |-> $stable(snap));

   assert_send_start_R4: assert property (@(posedge tx_clk) disable iff (tx_rst)
      (send && !busy) |=> (vld && busy));

   assert_burst_len_R7: assert property (@(posedge tx_clk) disable iff (tx_rst)
      (!vld && $past(vld)) |-> (run_q == RUN_W'(NB)));
endmodule

bind ts_snap_tx ts_snap_tx_chk #(.TS_W(TS_W)) u_chk (
   .cap_clk (cap_clk_i),
   .cap_rst (cap_rst_i),
   .tx_clk  (tx_clk_i),
   .tx_rst  (tx_rst_i),
   .sof_n   (sof_n_i),
   .send    (send_i),
   .vld     (byte_vld_o),
   .busy    (busy_o),
   .cnt     (cnt_w),
   .snap    (snap_w),
   .load    (load_w),
   .ready   (ready_w)
);

// File: tb/ts_snap_tx_tb_top.sv
module ts_snap_tx_tb_top;
   logic cap_clk = 1'b0;
   logic tx_clk  = 1'b0;
   logic cap_rst = 1'b1;
   logic tx_rst  = 1'b1;
   logic sof_r   = 1'b1;
   logic send_r  = 1'b0;
   logic send_w_r = 1'b0;
   logic run_cmp = 1'b0;

   logic [7:0] byte_m, byte_n;
   logic       vld_m, vld_n, busy_m, busy_n;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   always #5 cap_clk = ~cap_clk;
   always #4 tx_clk  = ~tx_clk;

   ts_snap_tx dut_i (
      .cap_clk_i (cap_clk), .cap_rst_i (cap_rst), .sof_n_i (sof_r),
      .tx_clk_i (tx_clk), .tx_rst_i (tx_rst), .send_i (send_r),
      .byte_o (byte_m), .byte_vld_o (vld_m), .busy_o (busy_m)
   );

   ts_snap_tx #(.TS_W(16), .SHIFT_OUT(1'b1)) dut_w_i (
      .cap_clk_i (cap_clk), .cap_rst_i (cap_rst), .sof_n_i (sof_r),
      .tx_clk_i (tx_clk), .tx_rst_i (tx_rst), .send_i (send_w_r),
      .byte_o (byte_n), .byte_vld_o (vld_n), .busy_o (busy_n)
   );

   // capture-domain reference: count, first-low detection, pending window
   longint unsigned mcnt = 0;
   longint unsigned exp_snap = 0;
   logic            m_prev = 1'b1;
   int              since = 1000;

   always @(posedge cap_clk) begin
      if (cap_rst) begin
         mcnt = 0; m_prev = 1'b1; since = 1000;
      end else begin
         if (!sof_r && m_prev && since >= 4) begin
            exp_snap = mcnt;
            since = 0;
         end else if (since < 1000) begin
            since++;
         end
         mcnt++;
         m_prev = sof_r;
      end
   end

   // transmit-domain reference for both instances
   logic [63:0] m_hold = '0, mf = '0;
   logic [15:0] m_hold2 = '0, mf2 = '0;
   bit mb = 0, mb2 = 0;
   int mi = 0, mi2 = 0;

   always @(posedge tx_clk) begin
      if (tx_rst) begin
         mb = 0; mb2 = 0;
      end else begin
         if (mb) begin
            if (mi == 0) mb = 0; else mi--;
         end else if (send_r) begin
            mb = 1; mi = 7; mf = m_hold;
         end
         if (mb2) begin
            if (mi2 == 0) mb2 = 0; else mi2--;
         end else if (send_w_r) begin
            mb2 = 1; mi2 = 1; mf2 = m_hold2;
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   always @(negedge tx_clk) begin
      if (run_cmp && !tx_rst) begin
         check({cur_req, " wide"}, {54'd0, byte_m, vld_m, busy_m},
               {54'd0, (mb ? mf[mi*8 +: 8] : 8'h00), mb, mb});
         check({cur_req, " narrow R9"}, {54'd0, byte_n, vld_n, busy_n},
               {54'd0, (mb2 ? mf2[mi2*8 +: 8] : 8'h00), mb2, mb2});
      end
   end

   task automatic cap_wait(input int n);
      repeat (n) @(negedge cap_clk);
   endtask

   task automatic tx_wait(input int n);
      repeat (n) @(negedge tx_clk);
   endtask

   task automatic sof_pulse(input int low_cycles);
      @(negedge cap_clk) sof_r = 1'b0;
      repeat (low_cycles) @(negedge cap_clk);
      sof_r = 1'b1;
   endtask

   task automatic tx_send(input bit both);
      @(negedge tx_clk);
      send_r = 1'b1;
      if (both) send_w_r = 1'b1;
      @(negedge tx_clk);
      send_r = 1'b0;
      send_w_r = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge tx_clk);
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      #60;
      @(negedge tx_clk);
      check("R1 byte", {56'd0, byte_m}, 64'd0);
      check("R1 valid", {63'd0, vld_m}, 64'd0);
      check("R1 busy", {63'd0, busy_m}, 64'd0);
      check("R1 narrow", {54'd0, byte_n, vld_n, busy_n}, 64'd0);
      #37;
      cap_rst = 1'b0;
      tx_rst  = 1'b0;
      run_cmp = 1'b1;

      // R2 R3 R4: basic capture and burst
      cur_req = "R2 R3 R4";
      cap_wait(37);
      sof_pulse(1);
      cap_wait(25);
      check("R2 snapshot taken", {63'd0, exp_snap != 0}, 64'd1);
      m_hold = exp_snap; m_hold2 = exp_snap[15:0];
      tx_send(1'b0);
      tx_wait(14);

      // R5: strobe held low captures once
      cur_req = "R5";
      cap_wait(13);
      sof_pulse(40);
      cap_wait(25);
      m_hold = exp_snap; m_hold2 = exp_snap[15:0];
      tx_send(1'b0);
      tx_wait(14);

      // R6: second fall while pending is dropped
      cur_req = "R6";
      cap_wait(7);
      @(negedge cap_clk) sof_r = 1'b0;
      @(negedge cap_clk) sof_r = 1'b1;
      @(negedge cap_clk) sof_r = 1'b0;
      @(negedge cap_clk) sof_r = 1'b1;
      cap_wait(25);
      m_hold = exp_snap; m_hold2 = exp_snap[15:0];
      tx_send(1'b0);
      tx_wait(14);

      // R7: send while busy ignored
      cur_req = "R7";
      @(negedge tx_clk) send_r = 1'b1;
      @(negedge tx_clk) send_r = 1'b0;
      tx_wait(2);
      send_r = 1'b1;
      tx_wait(2);
      send_r = 1'b0;
      tx_wait(12);

      // R8: capture during a burst does not disturb it; resend repeats
      cur_req = "R8";
      cap_wait(20);
      fork
         tx_send(1'b0);
         sof_pulse(1);
      join
      tx_wait(14);
      cap_wait(20);
      m_hold = exp_snap; m_hold2 = exp_snap[15:0];
      tx_send(1'b0);
      tx_wait(14);
      tx_send(1'b0);
      tx_wait(14);

      // R9: narrow instance past its wrap point
      cur_req = "R9";
      while (mcnt < 64'd65600) @(negedge cap_clk);
      sof_pulse(1);
      cap_wait(25);
      check("R9 count beyond wrap", {63'd0, exp_snap > 64'd65535}, 64'd1);
      m_hold = exp_snap; m_hold2 = exp_snap[15:0];
      tx_send(1'b1);
      tx_wait(14);

      finish_run();
   end
endmodule